// File: doc/BRIEF.md
# Half-Period Tone Divider

This block turns a tone-rate clock enable of about 65.5 kHz into a square-wave musical note for an alarm buzzer pin. An 8-bit counter does the work. Its low seven bits count out one half of the note. Its top bit is the note itself, and it flips each time the low bits reach the half length taken from a setting register. Bit 7 of the setting register asks for a trimmed period, in which the low half after each high half is one tick shorter. This lets the total divisor be odd as well as even.

The alarm pin carries the note while the alarm enable is high and tone mode is selected. When the alarm enable is high and tone mode is off, the pin carries a fixed reference tone instead. This tone is the tick rate divided by 2^REF_LOG2, which gives 4096 Hz from 65536 Hz at the default. When the alarm enable is low, the pin stays low. The tone clock itself comes from outside the block.

Top module: `tone_halfdiv`

## Requirements
- R1: After reset, `count` is 0 and `alarm_pin` is 0.
- R2: After a clear, the low half lasts N advancing ticks. N is `setting[6:0]`. At the tick where the incremented low bits would equal N, the low bits go to 0 and bit 7 of `count` becomes 1.
- R3: The high half is counted the same way. At its end, bit 7 returns to 0. With `setting[7]`=0, the note period is 2N ticks.
- R4: With `setting[7]`=1, the end of each high half loads the low bits with 1 instead of 0. The following low half is then N-1 ticks, so the steady note period is 2N-1 ticks.
- R5: Values of `setting[6:0]` below 2 behave as N=2.
- R6: `count` advances only on a clock where `tone_tick`, `count_en` and `tone_mode` are all 1 and `clr` is 0. Otherwise it holds.
- R7: `clr`=1 forces `count` to 0 at the next clock edge, whatever the other inputs are. It also takes the current `setting` at once.
- R8: A change to `setting` made in the middle of a half takes effect only at the next half-period end or clear.
- R9: With `alarm_en`=1 and `tone_mode`=1, `alarm_pin` equals bit 7 of `count`.
- R10: With `alarm_en`=0, `alarm_pin` is 0.
- R11: With `alarm_en`=1 and `tone_mode`=0, `alarm_pin` is a free-running square wave. It is high for 2^(REF_LOG2-1) ticks and low for the same number (8 and 8 at the default), whatever `count_en` is set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tone_tick | input | 1 | One-clock enable at the tone input rate |
| tone_mode | input | 1 | 1 selects note generation |
| setting | input | CW | Bit 7 trims the period; bits 6:0 hold the half length N |
| count_en | input | 1 | Count enable |
| clr | input | 1 | Synchronous clear of the counter |
| alarm_en | input | 1 | Alarm pin enable |
| count | output | CW | Counter value; top bit is the note |
| alarm_pin | output | 1 | Buzzer output |

## Verification
The bench uses the default build: CW=8, MIN_HALF=2, REF_LOG2=4 and a combinational pin. With the tick held high, one half lasts at most 127 clocks. This makes it cheap to measure run lengths of the note directly. The sweep covers N from 0 to 40 and from 120 to 127, each with and without the trim. This reaches the clamp values 0 and 1, the shortest trimmed period, and the widest halves. Separate stepped-tick sequences check exact counter values for gated ticks, for a setting change in mid-half, and for the trim reload of 1.

// File: rtl/tdiv_pkg.sv
package tdiv_pkg;
   typedef enum logic [1:0] {
      PIN_OFF  = 2'd0,
      PIN_NOTE = 2'd1,
      PIN_REF  = 2'd2
   } pin_src_e;

   function automatic pin_src_e pick_src(input logic en, input logic mode);
      if (!en)       return PIN_OFF;
      else if (mode) return PIN_NOTE;
      else           return PIN_REF;
   endfunction
endpackage

// File: rtl/tdiv_limit.sv
module tdiv_limit #(
   parameter int CW       = 8,
   parameter int MIN_HALF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] setting,
   output logic [CW-2:0] half_len,
   output logic          trim
);
   localparam int LW = CW - 1;

   logic [LW-1:0] clamped;

   always_comb begin
      clamped = setting[LW-1:0];
      if (clamped < LW'(MIN_HALF))
         clamped = LW'(MIN_HALF);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_len <= LW'(MIN_HALF);
         trim     <= 1'b0;
      end else if (load) begin
         half_len <= clamped;
         trim     <= setting[CW-1];
      end
   end
endmodule

// File: rtl/tdiv_halfcnt.sv
module tdiv_halfcnt #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          clr,
   input  logic [CW-2:0] half_len,
   input  logic          trim,
   output logic [CW-1:0] cnt,
   output logic          half_end
);
   localparam int LW = CW - 1;

   logic [LW-1:0] low_q;
   logic          note_q;
   logic [LW-1:0] low_inc;
   logic [LW-1:0] low_restart;

   assign low_inc     = low_q + 1'b1;
   assign half_end    = (low_inc == half_len);
   assign low_restart = (note_q && trim) ? LW'(1) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q  <= '0;
         note_q <= 1'b0;
      end else if (clr) begin
         low_q  <= '0;
         note_q <= 1'b0;
      end else if (step) begin
         if (half_end) begin
            low_q  <= low_restart;
            note_q <= ~note_q;
         end else begin
            low_q  <= low_inc;
         end
      end
   end

   assign cnt = {note_q, low_q};
endmodule

// File: rtl/tdiv_ref.sv
module tdiv_ref #(
   parameter int REF_LOG2 = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic ref_wave
);
   logic [REF_LOG2-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (tick) pre_q <= pre_q + 1'b1;
   end

   assign ref_wave = pre_q[REF_LOG2-1];
endmodule

// File: rtl/tdiv_pinmux.sv
module tdiv_pinmux
   import tdiv_pkg::*;
#(
   parameter bit PIN_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alarm_en,
   input  logic tone_mode,
   input  logic note,
   input  logic ref_wave,
   output logic pin
);
   pin_src_e src;
   logic     pin_d;

   always_comb begin
      src = pick_src(alarm_en, tone_mode);
      unique case (src)
         PIN_NOTE: pin_d = note;
         PIN_REF:  pin_d = ref_wave;
         default:  pin_d = 1'b0;
      endcase
   end

   generate
      if (PIN_REG) begin : g_reg
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= pin_d;
         end
         assign pin = pin_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign pin = pin_d;
      end
   endgenerate
endmodule

// File: rtl/tone_halfdiv.sv
module tone_halfdiv #(
   parameter int CW       = 8,
   parameter int MIN_HALF = 2,
   parameter int REF_LOG2 = 4,
   parameter bit PIN_REG  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tone_tick,
   input  logic          tone_mode,
   input  logic [CW-1:0] setting,
   input  logic          count_en,
   input  logic          clr,
   input  logic          alarm_en,
   output logic [CW-1:0] count,
   output logic          alarm_pin
);
   localparam int LW = CW - 1;

   generate
      if (CW < 3 || CW > 16) begin : g_bad_cw
         $error("tone_halfdiv: CW out of range");
      end
      if (MIN_HALF < 2 || MIN_HALF >= (1 << LW)) begin : g_bad_min
         $error("tone_halfdiv: MIN_HALF out of range");
      end
      if (REF_LOG2 < 1 || REF_LOG2 > 16) begin : g_bad_ref
         $error("tone_halfdiv: REF_LOG2 out of range");
      end
   endgenerate

   logic [LW-1:0] half_len;
   logic          trim;
   logic          step;
   logic          half_end;
   logic          ref_wave;
   logic          load;

   assign step = tone_tick & count_en & tone_mode & ~clr;
   assign load = clr | (step & half_end);

   tdiv_limit #(.CW(CW), .MIN_HALF(MIN_HALF)) u_limit (
      .clk(clk), .rst_n(rst_n), .load(load), .setting(setting),
      .half_len(half_len), .trim(trim)
   );

   tdiv_halfcnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .clr(clr),
      .half_len(half_len), .trim(trim), .cnt(count), .half_end(half_end)
   );

   tdiv_ref #(.REF_LOG2(REF_LOG2)) u_ref (
      .clk(clk), .rst_n(rst_n), .tick(tone_tick), .ref_wave(ref_wave)
   );

   tdiv_pinmux #(.PIN_REG(PIN_REG)) u_pin (
      .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en), .tone_mode(tone_mode),
      .note(count[CW-1]), .ref_wave(ref_wave), .pin(alarm_pin)
   );
endmodule

// File: rtl/tone_halfdiv_chk.sv
module tone_halfdiv_chk #(
   parameter int CW      = 8,
   parameter bit PIN_REG = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tone_tick,
   input logic          tone_mode,
   input logic          count_en,
   input logic          clr,
   input logic          alarm_en,
   input logic [CW-1:0] count,
   input logic          alarm_pin
);
   logic adv;
   assign adv = tone_tick & count_en & tone_mode & ~clr;

   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !adv) |=> $stable(count));

   a_r2_low_range: assert property (@(posedge clk) disable iff (!rst_n)
      count[CW-2:0] != '1);

   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> ((count[CW-1] != $past(count[CW-1]))
               ? (count[CW-2:0] <= (CW-1)'(1))
               : (count[CW-2:0] == $past(count[CW-2:0]) + 1'b1)));

   generate
      if (!PIN_REG) begin : g_pin_chk
         a_r10_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
            !alarm_en |-> !alarm_pin);
         a_r9_note_pin: assert property (@(posedge clk) disable iff (!rst_n)
            (alarm_en && tone_mode) |-> (alarm_pin == count[CW-1]));
      end
   endgenerate
endmodule

bind tone_halfdiv tone_halfdiv_chk #(.CW(CW), .PIN_REG(PIN_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .tone_tick(tone_tick), .tone_mode(tone_mode),
   .count_en(count_en), .clr(clr), .alarm_en(alarm_en),
   .count(count), .alarm_pin(alarm_pin)
);

// File: tb/sim_tone_halfdiv.sv
module sim_tone_halfdiv;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tone_tick = 1'b0;
   logic       tone_mode = 1'b0;
   logic [7:0] setting = '0;
   logic       count_en = 1'b0;
   logic       clr = 1'b0;
   logic       alarm_en = 1'b0;
   logic [7:0] count;
   logic       alarm_pin;

   int n_tests = 0;
   int n_fail  = 0;
   int runs[4];

   always #(CLK_PERIOD/2) clk = ~clk;

   tone_halfdiv u0 (
      .clk(clk), .rst_n(rst_n), .tone_tick(tone_tick), .tone_mode(tone_mode),
      .setting(setting), .count_en(count_en), .clr(clr), .alarm_en(alarm_en),
      .count(count), .alarm_pin(alarm_pin)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // clear with the current setting; returns at the negedge right after the clear edge
   task automatic do_clear();
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
   endtask

   // record four run lengths of alarm_pin starting at the current negedge
   task automatic collect(input bit skip_first);
      logic prev;
      int   len, idx;
      bit   skipping;
      prev = alarm_pin; len = 1; idx = 0; skipping = skip_first;
      for (int i = 0; i < 2000 && idx < 4; i++) begin
         @(negedge clk);
         if (alarm_pin == prev) len++;
         else begin
            if (skipping) skipping = 1'b0;
            else begin runs[idx] = len; idx++; end
            prev = alarm_pin; len = 1;
         end
      end
      for (int k = idx; k < 4; k++) runs[k] = -1;
   endtask

   task automatic ticks(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk) tone_tick = 1'b1;
         @(negedge clk) tone_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(count == 8'h00, "R1 count after reset", count, 0);
      chk(alarm_pin == 1'b0, "R1 pin after reset", alarm_pin, 0);
      rst_n = 1'b1;

      // sweep N and the trim bit with continuous ticks
      tone_mode = 1'b1; count_en = 1'b1; alarm_en = 1'b1; tone_tick = 1'b1;
      for (int t = 0; t < 2; t++) begin
         for (int n = 0; n < 128; n++) begin
            int eff;
            if (n > 40 && n < 120) continue;
            eff = (n < 2) ? 2 : n;
            @(negedge clk) setting = {t[0], n[6:0]};
            do_clear();
            collect(1'b0);
            chk(runs[0] == eff, (n < 2) ? "R5 R2 low half" : "R2 low half", runs[0], eff);
            chk(runs[1] == eff, (n < 2) ? "R5 R3 high half" : "R3 high half", runs[1], eff);
            chk(runs[2] == eff - t, "R4 trimmed low half", runs[2], eff - t);
            chk(runs[3] == eff, "R3 second high half", runs[3], eff);
         end
      end

      // reference tone with tone mode off
      tone_mode = 1'b0; count_en = 1'b0;
      @(negedge clk);
      collect(1'b1);
      chk(runs[0] == 8, "R11 ref run0", runs[0], 8);
      chk(runs[1] == 8, "R11 ref run1", runs[1], 8);
      chk(runs[2] == 8, "R11 ref run2", runs[2], 8);

      // stepped ticks: gating
      tone_tick = 1'b0; tone_mode = 1'b1; count_en = 1'b1;
      setting = 8'h05;
      do_clear();
      chk(count == 8'h00, "R7 cleared", count, 0);
      ticks(7);
      chk(count == 8'h82, "R6 stepped ticks", count, 8'h82);
      count_en = 1'b0; ticks(3);
      chk(count == 8'h82, "R6 hold count_en=0", count, 8'h82);
      count_en = 1'b1; tone_mode = 1'b0; ticks(3);
      chk(count == 8'h82, "R6 hold tone_mode=0", count, 8'h82);
      tone_mode = 1'b1;
      @(negedge clk) alarm_en = 1'b0;
      @(negedge clk);
      chk(alarm_pin == 1'b0, "R10 pin off", alarm_pin, 0);
      alarm_en = 1'b1;
      @(negedge clk);
      chk(alarm_pin == 1'b1, "R9 pin follows note", alarm_pin, 1);
      @(negedge clk) begin tone_tick = 1'b1; clr = 1'b1; end
      @(negedge clk) begin tone_tick = 1'b0; clr = 1'b0; end
      chk(count == 8'h00, "R7 clear beats tick", count, 0);

      // setting change mid-half
      setting = 8'h04;
      do_clear();
      ticks(2);
      setting = 8'h0A;
      ticks(2);
      chk(count == 8'h80, "R8 old length kept", count, 8'h80);
      ticks(9);
      chk(count == 8'h89, "R8 new length used", count, 8'h89);
      ticks(1);
      chk(count == 8'h00, "R8 new half end", count, 0);

      // trim reload value
      setting = 8'h83;
      do_clear();
      ticks(3);
      chk(count == 8'h80, "R4 trim first half", count, 8'h80);
      ticks(3);
      chk(count == 8'h01, "R4 trim reload one", count, 1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule